// File: doc/BRIEF.md
# Bus-Cycle Trace Serializer

This block sits beside an 8-bit CPU bus and turns selected bus cycles into readable text on a one-way serial line. A five-bit mask register chooses which cycle kinds are traced: opcode fetch, memory read, memory write, I/O read and I/O write. When a chosen cycle begins, the block pulls the CPU's READY input low, which holds the processor in that cycle. It captures the address and data, sends a short ASCII record describing the cycle, and then lets the CPU continue.

The mask is loaded from five switch inputs only while a load strobe is high. A new pattern can therefore be set up on the switches while the old one remains in force. Software can also switch tracing off and on by writing to two reserved I/O ports. This lets a busy polling loop run without producing records.

Transmission is paced by an external baud-rate enable tick. An internal slot counter advances by one on each tick. Its upper nibble picks the character of the record and its lower nibble picks the bit time within that character.

Top module: `bus_trace_serializer`

## Requirements
- R1: Mask bit 0 selects opcode fetch, bit 1 memory read, bit 2 memory write, bit 3 I/O read and bit 4 I/O write. A record starts on the clock in which a selected strobe rises while no record is in progress and tracing is on. A strobe whose mask bit is clear produces no stall.
- R2: `ready` goes low in the clock where the record starts and stays low for the whole record. It returns high on the clock after the baud tick that ends the stop bit of the final LF character.
- R3: The mask resets to zero. It takes the value of `sw_mask` only on clocks where `mask_load` is high. At all other times changes on the switches have no effect.
- R4: While the mask is zero, `ready` stays high and `txd` stays high for any bus activity.
- R5: A record is twelve characters in this order: a two-letter type, ',' (2Ch), four address hex digits with the most significant first, ' ' (20h), two data hex digits with the most significant first, CR (0Dh), LF (0Ah). The type codes are "M1" for opcode fetch, "MR" for memory read, "MW" for memory write, "IR" for I/O read and "IW" for I/O write. When several selected strobes rise together, the priority is M1, then MR, MW, IR, IW.
- R6: Hex digits use the values 30h–39h for 0–9 and 41h–46h for A–F.
- R7: Each character occupies sixteen baud ticks. The first is a low start bit, then eight data bits with the LSB first, then a high stop bit, then six high idle ticks. The count advances only on `baud_tick` while a record is in progress, and starts at the first character's start bit.
- R8: Address, data and type are captured when the record starts. Bus changes during the record do not alter the characters sent.
- R9: Tracing is on after reset. An I/O write to port 00h (the low eight address bits) turns tracing off and a write to port 01h turns it back on, whatever the mask holds. The write to 00h is itself traced if selected. The write to 01h is not traced.
- R10: `txd` is high whenever no record is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-clock enable per serial bit time |
| cyc_m1 | input | 1 | Opcode fetch cycle strobe |
| cyc_mr | input | 1 | Memory read cycle strobe |
| cyc_mw | input | 1 | Memory write cycle strobe |
| cyc_ir | input | 1 | I/O read cycle strobe |
| cyc_iw | input | 1 | I/O write cycle strobe |
| addr | input | ADDR_W | Bus address |
| data | input | DATA_W | Bus data |
| sw_mask | input | 5 | Switch value for the mask |
| mask_load | input | 1 | Mask load strobe |
| ready | output | 1 | CPU READY, low while stalled |
| txd | output | 1 | Serial trace output, idle high |

## Verification
The bench builds the block with its defaults: a 16-bit address, 8-bit data and a 4+4-bit slot counter. This yields the full twelve-character record and the sixteen-tick character slot. The baud tick is driven once every third clock. This keeps records short enough to run a dozen of them, while every tick still has idle clocks between steps so that counting on non-tick clocks would be exposed. Addresses containing the digits A–F, the data byte EF, simultaneous fetch and read strobes, and bus values changed in the middle of a stall cover the hex conversion, the type priority and the capture rule. The port-00h and port-01h writes cover the trace switch.

// File: rtl/trace_pkg.sv
package trace_pkg;

   localparam int NUM_CYC = 5;

   // index order is also the type priority (lowest index wins)
   typedef enum logic [2:0] {
      CY_M1 = 3'd0,
      CY_MR = 3'd1,
      CY_MW = 3'd2,
      CY_IR = 3'd3,
      CY_IW = 3'd4
   } cyc_e;

   function automatic logic [7:0] hex_ascii(input logic [3:0] nib);
      return (nib < 4'd10) ? (8'h30 + {4'h0, nib}) : (8'h37 + {4'h0, nib});
   endfunction

   function automatic logic [15:0] kind_text(input cyc_e k);
      case (k)
         CY_M1:   return 16'h4D31;
         CY_MR:   return 16'h4D52;
         CY_MW:   return 16'h4D57;
         CY_IR:   return 16'h4952;
         default: return 16'h4957;
      endcase
   endfunction

endpackage

// File: rtl/trace_trigger.sv
module trace_trigger
   import trace_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int PORT_W   = 8,
   parameter int OFF_PORT = 0,
   parameter int ON_PORT  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CYC-1:0] cyc_i,
   input  logic [NUM_CYC-1:0] sel_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               idle_i,
   output logic               fire_o,
   output cyc_e               kind_o
);

   logic [NUM_CYC-1:0] prev_q;
   logic [NUM_CYC-1:0] rise;
   logic [NUM_CYC-1:0] hit;
   logic               enable_q;

   assign rise   = cyc_i & ~prev_q;
   assign hit    = rise & sel_i;
   assign fire_o = idle_i && enable_q && (|hit);

   always_comb begin
      kind_o = CY_M1;
      for (int i = NUM_CYC - 1; i >= 0; i--) begin
         if (hit[i]) kind_o = cyc_e'(3'(i));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q   <= '0;
         enable_q <= 1'b1;
      end else begin
         prev_q <= cyc_i;
         if (rise[CY_IW]) begin
            if (addr_i[PORT_W-1:0] == PORT_W'(OFF_PORT)) enable_q <= 1'b0;
            else if (addr_i[PORT_W-1:0] == PORT_W'(ON_PORT)) enable_q <= 1'b1;
         end
      end
   end

   // R9: after a write to the off port, no record can start on the next clock
   p_off_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[CY_IW] && addr_i[PORT_W-1:0] == PORT_W'(OFF_PORT)) |=> !fire_o);

   // R1: a record only starts from a selected strobe
   p_sel_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> ((cyc_i & sel_i) != '0));

endmodule

// File: rtl/trace_fmt.sv
module trace_fmt
   import trace_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CHR_W  = 4
) (
   input  cyc_e              kind_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [CHR_W-1:0]  chr_i,
   output logic [7:0]        char_o,
   output logic              live_o
);

   localparam int SLOTS   = 2 ** CHR_W;
   localparam int A_DIG   = ADDR_W / 4;
   localparam int D_DIG   = DATA_W / 4;
   localparam int REC_LEN = 2 + 1 + A_DIG + 1 + D_DIG + 2;
   localparam int A_POS   = 3;
   localparam int D_POS   = A_POS + A_DIG + 1;

   if (ADDR_W % 4 != 0 || DATA_W % 4 != 0) begin : g_bad_width
      $error("trace_fmt: address and data widths must be whole nibbles");
   end
   if (REC_LEN > SLOTS) begin : g_bad_slots
      $error("trace_fmt: record does not fit in the character slots");
   end

   logic [15:0] ktxt;
   logic [7:0]  rec [SLOTS];

   assign ktxt   = kind_text(kind_i);
   assign rec[0] = ktxt[15:8];
   assign rec[1] = ktxt[7:0];
   assign rec[2] = 8'h2C;

   for (genvar g = 0; g < A_DIG; g++) begin : g_adig
      assign rec[A_POS+g] = hex_ascii(addr_i[(A_DIG-1-g)*4 +: 4]);
   end

   assign rec[A_POS+A_DIG] = 8'h20;

   for (genvar g = 0; g < D_DIG; g++) begin : g_ddig
      assign rec[D_POS+g] = hex_ascii(data_i[(D_DIG-1-g)*4 +: 4]);
   end

   assign rec[REC_LEN-2] = 8'h0D;
   assign rec[REC_LEN-1] = 8'h0A;

   for (genvar g = REC_LEN; g < SLOTS; g++) begin : g_pad
      assign rec[g] = 8'hFF;
   end

   assign char_o = rec[chr_i];
   assign live_o = (32'(chr_i) < REC_LEN);

endmodule

// File: rtl/trace_tx.sv
module trace_tx #(
   parameter int CHR_W     = 4,
   parameter int BIT_W     = 4,
   parameter int LAST_SLOT = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             tick_i,
   input  logic [7:0]       char_i,
   input  logic             live_i,
   output logic             busy_o,
   output logic [CHR_W-1:0] chr_o,
   output logic             txd_o
);

   localparam int CW       = CHR_W + BIT_W;
   localparam int STOP_POS = 9;
   localparam logic [CW-1:0] LAST = CW'(LAST_SLOT * (2 ** BIT_W) + STOP_POS);

   if ((2 ** BIT_W) <= STOP_POS) begin : g_bad_bits
      $error("trace_tx: bit field too narrow for a start, data and stop frame");
   end

   logic [CW-1:0]    cnt_q;
   logic [BIT_W-1:0] bit_sel;

   assign chr_o   = cnt_q[CW-1:BIT_W];
   assign bit_sel = cnt_q[BIT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_o) begin
         cnt_q <= '0;
         if (start_i) busy_o <= 1'b1;
      end else if (tick_i) begin
         if (cnt_q == LAST) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_comb begin
      txd_o = 1'b1;
      if (busy_o && live_i) begin
         if (bit_sel == '0) txd_o = 1'b0;
         else if (32'(bit_sel) <= 8) txd_o = char_i[3'(bit_sel - 1'b1)];
      end
   end

   // R7: every character slot opens with a low start bit
   p_start_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && bit_sel == '0) |-> !txd_o);

   // R7: the slot counter only moves on a baud tick
   p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !tick_i) |=> (busy_o && $stable(cnt_q)));

   // R2: the tick that ends the final stop bit ends the record
   p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && tick_i && cnt_q == LAST) |=> !busy_o);

   // R10: line is high outside a record
   p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> txd_o);

endmodule

// File: rtl/bus_trace_serializer.sv
module bus_trace_serializer
   import trace_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int PORT_W   = 8,
   parameter int OFF_PORT = 0,
   parameter int ON_PORT  = 1,
   parameter int CHR_W    = 4,
   parameter int BIT_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              cyc_m1,
   input  logic              cyc_mr,
   input  logic              cyc_mw,
   input  logic              cyc_ir,
   input  logic              cyc_iw,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic [4:0]        sw_mask,
   input  logic              mask_load,
   output logic              ready,
   output logic              txd
);

   localparam int REC_LEN = 2 + 1 + ADDR_W / 4 + 1 + DATA_W / 4 + 2;

   if (PORT_W > ADDR_W) begin : g_bad_port
      $error("bus_trace_serializer: port field wider than the address");
   end

   logic [NUM_CYC-1:0] cyc_vec;
   logic [NUM_CYC-1:0] sel_q;
   logic               fire;
   logic               busy;
   cyc_e               kind_d;
   cyc_e               kind_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  data_q;
   logic [CHR_W-1:0]   chr;
   logic [7:0]         chr_byte;
   logic               chr_live;

   assign cyc_vec = {cyc_iw, cyc_ir, cyc_mw, cyc_mr, cyc_m1};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= '0;
         kind_q <= CY_M1;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         if (mask_load) sel_q <= sw_mask;
         if (fire) begin
            kind_q <= kind_d;
            addr_q <= addr;
            data_q <= data;
         end
      end
   end

   trace_trigger #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .OFF_PORT(OFF_PORT), .ON_PORT(ON_PORT)
   ) i_trigger (
      .clk(clk), .rst_n(rst_n), .cyc_i(cyc_vec), .sel_i(sel_q), .addr_i(addr),
      .idle_i(!busy), .fire_o(fire), .kind_o(kind_d)
   );

   trace_fmt #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHR_W(CHR_W)
   ) i_fmt (
      .kind_i(kind_q), .addr_i(addr_q), .data_i(data_q), .chr_i(chr),
      .char_o(chr_byte), .live_o(chr_live)
   );

   trace_tx #(
      .CHR_W(CHR_W), .BIT_W(BIT_W), .LAST_SLOT(REC_LEN - 1)
   ) i_tx (
      .clk(clk), .rst_n(rst_n), .start_i(fire), .tick_i(baud_tick),
      .char_i(chr_byte), .live_i(chr_live), .busy_o(busy), .chr_o(chr),
      .txd_o(txd)
   );

   assign ready = !(busy || fire);

   // R3: the mask only follows the switches under the load strobe
   p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_load |=> $stable(sel_q));

   // R4: an empty mask and no record in flight never stalls
   p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q == '0 && !busy) |-> ready);

   // R8: captured bus values hold for the whole record
   p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q)));

   // R2: the CPU is held for every clock of a record
   p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ready);

endmodule

// File: tb/test_bus_trace_serializer.sv
`timescale 1ns/1ps
module test_bus_trace_serializer;

   localparam int LAST_IDX = 11 * 16 + 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        baud_tick = 1'b0;
   logic [4:0]  strb = '0;
   logic [15:0] addr = '0;
   logic [7:0]  data = '0;
   logic [4:0]  sw_mask = '0;
   logic        mask_load = 1'b0;
   logic        ready;
   logic        txd;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   bus_trace_serializer i_bus_trace_serializer (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cyc_m1(strb[0]), .cyc_mr(strb[1]), .cyc_mw(strb[2]),
      .cyc_ir(strb[3]), .cyc_iw(strb[4]),
      .addr(addr), .data(data), .sw_mask(sw_mask), .mask_load(mask_load),
      .ready(ready), .txd(txd)
   );

   // baud tick every third clock
   int tdiv = 0;
   always @(negedge clk) begin
      #1;
      tdiv = (tdiv == 2) ? 0 : tdiv + 1;
      baud_tick = (tdiv == 2);
   end

   // ---------------- reference model ----------------
   bit       m_busy = 0;
   int       m_ticks = 0;
   bit       m_en = 1;
   bit [4:0] m_sel = '0;
   bit [4:0] m_prev = '0;
   bit       m_bits [0:255];

   function automatic byte hexc(input bit [3:0] n);
      string digits = "0123456789ABCDEF";
      return digits[n];
   endfunction

   task automatic build(input int k, input bit [15:0] a, input bit [7:0] d);
      string names [5] = '{"M1", "MR", "MW", "IR", "IW"};
      byte rec [12];
      rec[0] = names[k][0];
      rec[1] = names[k][1];
      rec[2] = ",";
      rec[3] = hexc(a[15:12]);
      rec[4] = hexc(a[11:8]);
      rec[5] = hexc(a[7:4]);
      rec[6] = hexc(a[3:0]);
      rec[7] = " ";
      rec[8] = hexc(d[7:4]);
      rec[9] = hexc(d[3:0]);
      rec[10] = 8'h0D;
      rec[11] = 8'h0A;
      for (int c = 0; c < 16; c++) begin
         for (int b = 0; b < 16; b++) begin
            if (c >= 12) m_bits[c*16+b] = 1'b1;
            else if (b == 0) m_bits[c*16+b] = 1'b0;
            else if (b <= 8) m_bits[c*16+b] = rec[c][b-1];
            else m_bits[c*16+b] = 1'b1;
         end
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_ticks = 0; m_en = 1; m_sel = '0; m_prev = '0;
      end else begin
         bit [4:0] rise;
         rise = strb & ~m_prev;
         if (!m_busy) begin
            if (m_en && (rise & m_sel) != 0) begin
               int k;
               k = 4;
               for (int i = 4; i >= 0; i--) if (rise[i] && m_sel[i]) k = i;
               build(k, addr, data);
               m_busy = 1;
               m_ticks = 0;
            end
         end else if (baud_tick) begin
            if (m_ticks == LAST_IDX) m_busy = 0;
            else m_ticks++;
         end
         if (rise[4] && addr[7:0] == 8'h00) m_en = 0;
         else if (rise[4] && addr[7:0] == 8'h01) m_en = 1;
         if (mask_load) m_sel = sw_mask;
         m_prev = strb;
      end
   end

   // per-clock comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_ready, exp_tx;
         exp_ready = !m_busy;
         exp_tx = m_busy ? m_bits[m_ticks] : 1'b1;
         checks++;
         if (ready !== exp_ready) begin
            errors++;
            $display("FAIL R2 ready at %0t: got %b expected %b", $time, ready, exp_ready);
         end
         checks++;
         if (txd !== exp_tx) begin
            errors++;
            if (m_busy)
               $display("FAIL R5 R6 R7 R8 txd tick %0d: got %b expected %b", m_ticks, txd, exp_tx);
            else
               $display("FAIL R10 idle txd: got %b expected %b", txd, exp_tx);
         end
      end
   end

   task automatic check(input bit ok, input string req, input int got, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic load_mask(input bit [4:0] m);
      @(negedge clk); #1;
      sw_mask = m; mask_load = 1'b1;
      @(negedge clk); #1;
      mask_load = 1'b0;
   endtask

   task automatic bus_cycle(input bit [4:0] s, input bit [15:0] a, input bit [7:0] d,
                            input bit exp_stall, input bit scramble, input string req);
      bit stalled;
      stalled = 0;
      @(negedge clk); #1;
      strb = s; addr = a; data = d;
      forever begin
         @(negedge clk);
         if (ready) break;
         stalled = 1;
         if (scramble) begin
            #1; addr = ~a; data = ~d;
         end
      end
      #1;
      strb = '0;
      @(negedge clk);
      check(stalled == exp_stall, req, stalled, exp_stall);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // reset state: R2 R10, and R3 mask zero (no stall)
      check(ready === 1'b1, "R2 reset ready", ready, 1);
      check(txd === 1'b1, "R10 reset txd", txd, 1);
      bus_cycle(5'b00001, 16'h1234, 8'h5A, 0, 0, "R3 reset mask empty");

      load_mask(5'b00001);
      bus_cycle(5'b00001, 16'h1234, 8'h5A, 1, 0, "R1 fetch selected");
      bus_cycle(5'b00010, 16'h2000, 8'h11, 0, 0, "R1 memory read unselected");

      load_mask(5'b11111);
      @(negedge clk); #1 sw_mask = 5'b00000;   // no load strobe: R3
      bus_cycle(5'b00010, 16'hABCD, 8'hEF, 1, 1, "R3 R6 R8 read with hex letters");
      bus_cycle(5'b00100, 16'h0F0F, 8'h3C, 1, 0, "R5 memory write");
      bus_cycle(5'b01000, 16'h0042, 8'h99, 1, 0, "R5 io read");
      bus_cycle(5'b00011, 16'h0100, 8'hC3, 1, 0, "R5 fetch priority");

      bus_cycle(5'b10000, 16'h0000, 8'h00, 1, 0, "R9 off write traced");
      bus_cycle(5'b00010, 16'h0300, 8'h77, 0, 0, "R9 tracing off");
      bus_cycle(5'b10000, 16'h0001, 8'h01, 0, 0, "R9 on write not traced");
      bus_cycle(5'b00010, 16'h0301, 8'h78, 1, 0, "R9 tracing back on");
      bus_cycle(5'b10000, 16'h0055, 8'hA5, 1, 0, "R1 R5 io write");

      load_mask(5'b00000);
      bus_cycle(5'b00001, 16'h4444, 8'h44, 0, 0, "R4 empty mask fetch");
      bus_cycle(5'b10000, 16'h0010, 8'h02, 0, 0, "R4 empty mask io write");

      repeat (4) @(negedge clk);
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule